// File: doc/BRIEF.md
# Burst Block Move and Fill Engine

This engine transfers a run of 32-bit words between a small local register file and a larger shared memory, in either direction. One command pulse carries the direction, the two start addresses, a count register and a fill element size. The low bits of the count register hold the word count minus one. Bit 31 of the count register turns the copy into a fill. A fill fetches one source word, spreads it across the lanes according to the element size, and writes it to every destination location.

The shared memory serves this engine only in its own slot of a fixed rotating schedule. A burst toward or from shared memory waits for that slot. Once it starts, it moves one word per clock. A long request is cut into bursts of at most sixteen words. Each burst first fills a staging buffer from the source and then drains the buffer into the destination. Both memories are plain synchronous ports with one clock of read latency. The engine raises `busy` while it works and pulses `done` when the last write has been made.

Top module: `blkf_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `shr_req`, `shr_we`, `lcl_re` and `lcl_we` are all low.
- R2: The count field `count_reg[CNT_W-1:0]` holds N-1. A plain move reads exactly N source words and writes exactly N destination words, so a field of 0 moves one word.
- R3: When `count_reg[31]` is 1 the command is a fill. The source is read exactly once, at the source address, and that value is written to N consecutive destination addresses. A field of 0 with the fill flag makes exactly one write.
- R4: The fill value is spread by `elem_size`. 2'b00 copies bits 7:0 into all four byte lanes. 2'b01 copies bits 15:0 into both halves. 2'b10 and 2'b11 keep the 32-bit word unchanged.
- R5: A move whose source address is numerically below its destination address runs from the highest address downward, so its first write goes to destination+N-1. Every other move, and every fill, runs upward with its first write at the destination address.
- R6: A slot counter clears on reset, advances once per clock and wraps modulo SLOTS (8). Every burst of shared-memory accesses begins in a cycle where that counter equals SLOT_ID. Within a burst, accesses fall on consecutive clocks.
- R7: No run of consecutive shared-memory accesses is longer than BURST (16) words. Longer requests take several bursts until the count reaches zero.
- R8: `start` is taken only when the engine is idle. A pulse while `busy` is high, or in the cycle `done` is high, is ignored and changes no memory.
- R9: `busy` goes high in the cycle after an accepted `start` and stays high through the last write. `done` is high for exactly one cycle, the cycle after the last write, and `busy` is low in that cycle.
- R10: `to_shared`=1 copies from the local register file into shared memory. `to_shared`=0 copies from shared memory into the local register file. Only the destination memory is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command pulse, sampled while idle |
| to_shared | input | 1 | 1: local to shared, 0: shared to local |
| src_addr | input | SA_W | Source start address (low LA_W bits when local) |
| dst_addr | input | SA_W | Destination start address (low LA_W bits when local) |
| count_reg | input | 32 | Bit 31 fill flag, low CNT_W bits hold N-1 |
| elem_size | input | 2 | Fill lane size: 00 byte, 01 half, 10/11 full word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| lcl_re | output | 1 | Local register file read strobe |
| lcl_we | output | 1 | Local register file write strobe |
| lcl_addr | output | LA_W | Local register file address |
| lcl_wdata | output | 32 | Local write data |
| lcl_rdata | input | 32 | Local read data, one clock after `lcl_re` |
| shr_req | output | 1 | Shared memory access (read or write) |
| shr_we | output | 1 | Shared memory write strobe |
| shr_addr | output | SA_W | Shared memory address |
| shr_wdata | output | 32 | Shared write data |
| shr_rdata | input | 32 | Shared read data, one clock after a read request |

## Verification
Two events can land on the same clock. The first is a new `start` arriving in the cycle where `done` pulses. The second is a `start` arriving mid-transfer while the engine is still writing. The bench raises `start` with a different, destructive fill command in exactly the `done` cycle of every transaction, and during `busy` for longer ones. It then compares both entire memories against a model that applies only the first command. A second collision is between the end of one shared burst and the next slot opening, which would merge two bursts. Sixteen-word fills are aligned so that this would happen. The bench watches every run of shared accesses for its start slot and its length.

// File: rtl/blkf_pkg.sv
package blkf_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'b00,
        ESZ_HALF = 2'b01,
        ESZ_WORD = 2'b10,
        ESZ_RSVD = 2'b11
    } elem_sz_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_READ,
        ST_DRAIN,
        ST_WRITE,
        ST_FIN
    } eng_st_e;

    typedef struct packed {
        logic     to_shared;
        logic     fill;
        logic     rev;
        elem_sz_e esz;
    } xfer_mode_t;

    localparam int FILL_FLAG_BIT = 31;

    // replicate the low lane of a fill value across the 32-bit word
    function automatic logic [31:0] spread(input logic [31:0] v, input elem_sz_e s);
        logic [31:0] r;
        case (s)
            ESZ_BYTE: r = {4{v[7:0]}};
            ESZ_HALF: r = {2{v[15:0]}};
            default:  r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/blkf_slot_timer.sv
module blkf_slot_timer #(
    parameter int SLOTS   = 8,
    parameter int SLOT_ID = 0
) (
    input  logic clk,
    input  logic rst,
    output logic slot_hit
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SW-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (slot_q == SW'(SLOTS - 1))
            slot_q <= '0;
        else
            slot_q <= slot_q + SW'(1);
    end

    assign slot_hit = (slot_q == SW'(SLOT_ID));
endmodule

// File: rtl/blkf_word_buf.sv
module blkf_word_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/blkf_addr_step.sv
module blkf_addr_step #(
    parameter int AW = 12,
    parameter int OW = 11
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] off,
    input  logic          rev,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] off_w;

    generate
        if (OW >= AW) begin : g_trunc
            assign off_w = off[AW-1:0];
        end else begin : g_ext
            assign off_w = {{(AW-OW){1'b0}}, off};
        end
    endgenerate

    assign ptr = rev ? (base - off_w) : (base + off_w);
endmodule

// File: rtl/blkf_engine.sv
module blkf_engine
    import blkf_pkg::*;
#(
    parameter int SA_W    = 12,
    parameter int LA_W    = 9,
    parameter int CNT_W   = 10,
    parameter int BURST   = 16,
    parameter int SLOTS   = 8,
    parameter int SLOT_ID = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            to_shared,
    input  logic [SA_W-1:0] src_addr,
    input  logic [SA_W-1:0] dst_addr,
    input  logic [31:0]     count_reg,
    input  logic [1:0]      elem_size,
    output logic            busy,
    output logic            done,
    output logic            lcl_re,
    output logic            lcl_we,
    output logic [LA_W-1:0] lcl_addr,
    output logic [31:0]     lcl_wdata,
    input  logic [31:0]     lcl_rdata,
    output logic            shr_req,
    output logic            shr_we,
    output logic [SA_W-1:0] shr_addr,
    output logic [31:0]     shr_wdata,
    input  logic [31:0]     shr_rdata
);
    localparam int CW1 = CNT_W + 1;
    localparam int BW  = $clog2(BURST + 1);
    localparam int IW  = $clog2(BURST);

    eng_st_e        st_q;
    xfer_mode_t     mode_q;
    logic [SA_W-1:0] src_base_q, dst_base_q;
    logic [CW1-1:0] rem_q, off_q;
    logic [BW-1:0]  blen_q, idx_q;
    logic           open_q;
    logic           cap_v_q;
    logic [BW-1:0]  cap_idx_q;
    logic [31:0]    fill_val_q;
    logic           fill_ld_q;

    logic            slot_hit;
    logic [CNT_W-1:0] field;
    logic            cmd_fill, cmd_rev;
    logic [CW1-1:0]  step, src_off;
    logic [SA_W-1:0] src_ptr, dst_ptr;
    logic            src_shr, dst_shr;
    logic            go_rd, go_wr, rd_go, wr_go;
    logic [BW-1:0]   rd_len;
    logic            rd_last, wr_last;
    logic [31:0]     cap_data, buf_rdata, wr_data;
    logic            unused_cnt_bits;

    assign unused_cnt_bits = ^count_reg[FILL_FLAG_BIT-1:CNT_W];

    // command decode at acceptance
    assign field    = count_reg[CNT_W-1:0];
    assign cmd_fill = count_reg[FILL_FLAG_BIT];
    assign cmd_rev  = !cmd_fill && (src_addr < dst_addr);

    // shared slot schedule
    blkf_slot_timer #(
        .SLOTS  (SLOTS),
        .SLOT_ID(SLOT_ID)
    ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .slot_hit(slot_hit)
    );

    // address generation: a fill always reads its one source word
    assign step    = off_q + CW1'(idx_q);
    assign src_off = mode_q.fill ? '0 : step;

    blkf_addr_step #(.AW(SA_W), .OW(CW1)) u_src_step (
        .base(src_base_q),
        .off (src_off),
        .rev (mode_q.rev),
        .ptr (src_ptr)
    );

    blkf_addr_step #(.AW(SA_W), .OW(CW1)) u_dst_step (
        .base(dst_base_q),
        .off (step),
        .rev (mode_q.rev),
        .ptr (dst_ptr)
    );

    // access gating
    assign src_shr = !mode_q.to_shared;
    assign dst_shr =  mode_q.to_shared;
    assign go_rd   = src_shr ? (open_q || slot_hit) : 1'b1;
    assign go_wr   = dst_shr ? (open_q || slot_hit) : 1'b1;
    assign rd_go   = (st_q == ST_READ)  && go_rd;
    assign wr_go   = (st_q == ST_WRITE) && go_wr;
    assign rd_len  = mode_q.fill ? BW'(1) : blen_q;
    assign rd_last = (idx_q == rd_len - BW'(1));
    assign wr_last = (idx_q == blen_q - BW'(1));

    // staging buffer
    assign cap_data = src_shr ? shr_rdata : lcl_rdata;

    blkf_word_buf #(.DEPTH(BURST), .DW(32)) u_buf (
        .clk  (clk),
        .we   (cap_v_q),
        .waddr(IW'(cap_idx_q)),
        .wdata(cap_data),
        .raddr(IW'(idx_q)),
        .rdata(buf_rdata)
    );

    assign wr_data = mode_q.fill ? fill_val_q : buf_rdata;

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            mode_q     <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
            rem_q      <= '0;
            off_q      <= '0;
            blen_q     <= '0;
            idx_q      <= '0;
            open_q     <= 1'b0;
            cap_v_q    <= 1'b0;
            cap_idx_q  <= '0;
            fill_val_q <= '0;
            fill_ld_q  <= 1'b0;
        end else begin
            cap_v_q <= 1'b0;
            if (cap_v_q && mode_q.fill) begin
                fill_val_q <= spread(cap_data, mode_q.esz);
                fill_ld_q  <= 1'b1;
            end
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q.to_shared <= to_shared;
                        mode_q.fill      <= cmd_fill;
                        mode_q.rev       <= cmd_rev;
                        mode_q.esz       <= elem_sz_e'(elem_size);
                        src_base_q <= cmd_rev ? src_addr + SA_W'(field) : src_addr;
                        dst_base_q <= cmd_rev ? dst_addr + SA_W'(field) : dst_addr;
                        rem_q      <= CW1'(field) + CW1'(1);
                        off_q      <= '0;
                        fill_ld_q  <= 1'b0;
                        st_q       <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    blen_q <= (rem_q > CW1'(BURST)) ? BW'(BURST) : BW'(rem_q);
                    idx_q  <= '0;
                    open_q <= 1'b0;
                    st_q   <= (mode_q.fill && fill_ld_q) ? ST_WRITE : ST_READ;
                end
                ST_READ: begin
                    if (go_rd) begin
                        cap_v_q   <= 1'b1;
                        cap_idx_q <= idx_q;
                        open_q    <= 1'b1;
                        if (rd_last) begin
                            idx_q  <= '0;
                            open_q <= 1'b0;
                            st_q   <= ST_DRAIN;
                        end else begin
                            idx_q <= idx_q + BW'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    st_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (go_wr) begin
                        open_q <= 1'b1;
                        if (wr_last) begin
                            idx_q  <= '0;
                            open_q <= 1'b0;
                            off_q  <= off_q + CW1'(blen_q);
                            rem_q  <= rem_q - CW1'(blen_q);
                            st_q   <= (rem_q == CW1'(blen_q)) ? ST_FIN : ST_PLAN;
                        end else begin
                            idx_q <= idx_q + BW'(1);
                        end
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // port drive
    assign shr_req   = (rd_go && src_shr) || (wr_go && dst_shr);
    assign shr_we    = wr_go && dst_shr;
    assign lcl_re    = rd_go && !src_shr;
    assign lcl_we    = wr_go && !dst_shr;
    assign shr_addr  = (st_q == ST_READ) ? src_ptr : dst_ptr;
    assign lcl_addr  = LA_W'((st_q == ST_READ) ? src_ptr : dst_ptr);
    assign shr_wdata = wr_data;
    assign lcl_wdata = wr_data;
    assign busy      = (st_q != ST_IDLE) && (st_q != ST_FIN);
    assign done      = (st_q == ST_FIN);
endmodule

// File: rtl/blkf_engine_chk.sv
module blkf_engine_chk #(
    parameter int SLOTS   = 8,
    parameter int SLOT_ID = 0,
    parameter int BURST   = 16
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic shr_req,
    input logic shr_we,
    input logic lcl_we
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SW-1:0] slot_c;
    logic          prev_req;
    logic [7:0]    run_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_c   <= '0;
            prev_req <= 1'b0;
            run_c    <= '0;
        end else begin
            slot_c   <= (slot_c == SW'(SLOTS - 1)) ? '0 : slot_c + SW'(1);
            prev_req <= shr_req;
            run_c    <= shr_req ? ((run_c == 8'hFF) ? run_c : run_c + 8'd1) : 8'd0;
        end
    end

    AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (shr_req && !prev_req) |-> (slot_c == SW'(SLOT_ID))); // R6

    AST_BURST_CAP: assert property (@(posedge clk) disable iff (rst)
        run_c <= 8'(BURST)); // R7

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (shr_we || lcl_we) |-> busy); // R9

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
        !(shr_we && lcl_we)); // R10
endmodule

bind blkf_engine blkf_engine_chk #(
    .SLOTS  (SLOTS),
    .SLOT_ID(SLOT_ID),
    .BURST  (BURST)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .shr_req(shr_req),
    .shr_we (shr_we),
    .lcl_we (lcl_we)
);

// File: tb/blkf_engine_tb.sv
module blkf_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SA_W = 12;
    localparam int LA_W = 9;
    localparam int CNT_W = 10;
    localparam int SLOT_ID = 0;
    localparam int SDEPTH = 1 << SA_W;
    localparam int LDEPTH = 1 << LA_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic to_shared = 1'b0;
    logic [SA_W-1:0] src_addr = '0, dst_addr = '0;
    logic [31:0] count_reg = '0;
    logic [1:0] elem_size = '0;
    logic busy, done, lcl_re, lcl_we, shr_req, shr_we;
    logic [LA_W-1:0] lcl_addr;
    logic [SA_W-1:0] shr_addr;
    logic [31:0] lcl_wdata, shr_wdata;
    logic [31:0] lcl_rdata = '0, shr_rdata = '0;

    logic [31:0] shr_m [SDEPTH];
    logic [31:0] lcl_m [LDEPTH];
    logic [31:0] exp_shr [SDEPTH];
    logic [31:0] exp_lcl [LDEPTH];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_total = 0, wr_total = 0, slot_bad = 0, run_bad = 0, run_len = 0;
    int wr_mark = 0;
    int first_wr = -1;
    bit prev_req = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkf_engine #(.SA_W(SA_W), .LA_W(LA_W), .CNT_W(CNT_W), .SLOT_ID(SLOT_ID)) u_dut (
        .clk(clk), .rst(rst), .start(start), .to_shared(to_shared),
        .src_addr(src_addr), .dst_addr(dst_addr), .count_reg(count_reg),
        .elem_size(elem_size), .busy(busy), .done(done),
        .lcl_re(lcl_re), .lcl_we(lcl_we), .lcl_addr(lcl_addr),
        .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
        .shr_req(shr_req), .shr_we(shr_we), .shr_addr(shr_addr),
        .shr_wdata(shr_wdata), .shr_rdata(shr_rdata)
    );

    // memory models with one clock of read latency
    always @(posedge clk) begin
        if (shr_we) shr_m[shr_addr] <= shr_wdata;
        shr_rdata <= shr_m[shr_addr];
        if (lcl_we) lcl_m[lcl_addr] <= lcl_wdata;
        lcl_rdata <= lcl_m[lcl_addr];
        cyc <= rst ? 0 : cyc + 1;
    end

    // port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if ((shr_req && !shr_we) || lcl_re) rd_total <= rd_total + 1;
            if (shr_we || lcl_we) begin
                if (wr_total == wr_mark) first_wr <= shr_we ? int'(shr_addr) : int'(lcl_addr);
                wr_total <= wr_total + 1;
            end
            if (shr_req && !prev_req && (cyc % 8) != SLOT_ID) slot_bad <= slot_bad + 1;
            if (shr_req) begin
                if (run_len + 1 > 16) run_bad <= run_bad + 1;
                run_len <= run_len + 1;
            end else begin
                run_len <= 0;
            end
            prev_req <= shr_req;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rep(input logic [31:0] v, input logic [1:0] s);
        if (s == 2'b00) return {v[7:0], v[7:0], v[7:0], v[7:0]};
        if (s == 2'b01) return {v[15:0], v[15:0]};
        return v;
    endfunction

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run(input bit to_sh, input int src, input int dst, input int fld,
                       input bit fill, input logic [1:0] esz, input bit poke);
        int n, rd0, wr0, sb0, rb0, bad_s, bad_l, exp_first;
        bit rev;
        logic [31:0] v;
        n = fld + 1;
        rev = !fill && (src < dst);
        foreach (shr_m[i]) exp_shr[i] = shr_m[i];
        foreach (lcl_m[i]) exp_lcl[i] = lcl_m[i];
        if (fill) begin
            v = rep(to_sh ? lcl_m[src] : shr_m[src], esz);
            for (int i = 0; i < n; i++)
                if (to_sh) exp_shr[dst+i] = v; else exp_lcl[dst+i] = v;
        end else begin
            for (int k = 0; k < n; k++) begin
                int i;
                i = rev ? n - 1 - k : k;
                if (to_sh) exp_shr[dst+i] = lcl_m[src+i]; else exp_lcl[dst+i] = shr_m[src+i];
            end
        end
        exp_first = rev ? dst + n - 1 : dst;
        rd0 = rd_total; wr0 = wr_total; sb0 = slot_bad; rb0 = run_bad;
        wr_mark = wr_total;
        @(negedge clk);
        to_shared = to_sh; src_addr = SA_W'(src); dst_addr = SA_W'(dst);
        count_reg = {fill, 21'd0, CNT_W'(fld)}; elem_size = esz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", longint'(busy), 1);
        if (poke) begin
            // R8: destructive command while busy must be ignored
            @(negedge clk);
            to_shared = ~to_sh; src_addr = '0; dst_addr = '0;
            count_reg = 32'h8000_0007; elem_size = 2'b00; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(busy === 1'b0, "R9 busy low with done", longint'(busy), 0);
        // R8: start in the done cycle is ignored
        to_shared = ~to_sh; src_addr = '0; dst_addr = '0;
        count_reg = 32'h8000_0003; elem_size = 2'b01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0 && busy === 1'b0, "R9 done single pulse / R8 idle",
            longint'({done, busy}), 0);
        @(negedge clk);
        chk(busy === 1'b0, "R8 start in done cycle ignored", longint'(busy), 0);
        bad_s = 0; bad_l = 0;
        foreach (shr_m[i]) if (shr_m[i] !== exp_shr[i]) bad_s++;
        foreach (lcl_m[i]) if (lcl_m[i] !== exp_lcl[i]) bad_l++;
        chk(bad_s == 0, fill ? "R3/R4/R10 shared contents" : "R2/R5/R10 shared contents", bad_s, 0);
        chk(bad_l == 0, fill ? "R3/R4/R10 local contents" : "R2/R5/R10 local contents", bad_l, 0);
        chk(rd_total - rd0 == (fill ? 1 : n), fill ? "R3 single source read" : "R2 source reads",
            rd_total - rd0, fill ? 1 : n);
        chk(wr_total - wr0 == n, "R2 destination writes", wr_total - wr0, n);
        chk(first_wr == exp_first, "R5 first write address", first_wr, exp_first);
        chk(slot_bad == sb0, "R6 burst slot alignment", slot_bad - sb0, 0);
        chk(run_bad == rb0, "R7 burst length", run_bad - rb0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < SDEPTH; i++) shr_m[i] = (32'h9E3779B9 * i) ^ (i << 7);
        for (int i = 0; i < LDEPTH; i++) lcl_m[i] = ~((32'h7F4A7C15 * i) ^ (i << 3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !shr_req && !shr_we && !lcl_re && !lcl_we, "R1 reset state",
            longint'({busy, done, shr_req, shr_we, lcl_re, lcl_we}), 0);
        shr_m[100] = 32'h1234_56C3;
        lcl_m[20]  = 32'hABCD_9E71;
        run(1'b0, 100, 30, 0, 1'b1, 2'b00, 1'b0);  // R3 field 0 fill, byte lane
        run(1'b0, 100, 40, 5, 1'b1, 2'b01, 1'b1);  // R4 half fill
        run(1'b1, 20, 200, 16, 1'b1, 2'b10, 1'b1); // R4 word fill, two bursts R7
        run(1'b1, 20, 600, 47, 1'b1, 2'b11, 1'b1); // R4 reserved size, three full bursts
        run(1'b1, 20, 700, 15, 1'b1, 2'b00, 1'b1); // R6 exact 16-word burst
        run(1'b0, 500, 10, 0, 1'b0, 2'b00, 1'b0);  // R2 single word move
        run(1'b0, 5, 300, 39, 1'b0, 2'b00, 1'b1);  // R5 reverse, multi-burst
        run(1'b1, 400, 100, 20, 1'b0, 2'b00, 1'b1);// R5 forward src > dst
        run(1'b1, 64, 64, 9, 1'b0, 2'b00, 1'b1);   // R5 equal addresses forward
        for (int t = 0; t < 12; t++) begin
            int fld, s, d;
            bit dir, fl;
            dir = 1'($urandom_range(0, 1));
            fl  = ($urandom_range(0, 2) == 0);
            fld = $urandom_range(0, 39);
            s = dir ? $urandom_range(0, LDEPTH - 41) : $urandom_range(0, SDEPTH - 41);
            d = dir ? $urandom_range(0, SDEPTH - 41) : $urandom_range(0, LDEPTH - 41);
            run(dir, s, d, fld, fl, 2'($urandom_range(0, 3)), fld >= 3);
        end
        finished = 1'b1;
        report();
    end
endmodule